// File: doc/BRIEF.md
# Debug Trigger Sequencer

The sequencer watches every bus cycle while armed and decides when a debug trigger has occurred. It combines two comparator hit signals (channel A and channel B), a data-access qualifier and an address window check into one of nine trigger conditions. It reports the trigger through a sticky flag. A capture-enable output tells downstream trace logic when to record. This enable either opens at the trigger or closes at it.

Software arms the block with a one-cycle strobe. On that strobe the block latches the condition code and the capture direction and clears any sequence history. Two condition codes never fire. In those codes each channel-B hit raises a one-cycle store strobe, so that the trace logic can keep the data of that cycle. The comparator values themselves and the trace storage sit outside this block.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset, and until the first arm strobe, trig_o, cap_en_o and store_o are all 0 and no bus cycle is evaluated.
- R2: A cycle with arm_i=1 latches mode_i and cap_begin_i. It clears trig_o, store_o and the A-seen history, and the bus inputs of that same cycle are not evaluated. Changes to mode_i or cap_begin_i after the arm strobe have no effect.
- R3: Mode 0 (A only) fires on a cycle with match_a_i=1. Mode 1 (A or B) fires on a cycle with match_a_i=1 or match_b_i=1.
- R4: Mode 2 (A then B) fires only on a match_b_i cycle that comes strictly after an earlier cycle with match_a_i=1 since the arm. A and B on the same single cycle does not fire.
- R5: Mode 5 fires on match_a_i & match_b_i & data_acc_i. Mode 6 fires on match_a_i & !match_b_i & data_acc_i.
- R6: Mode 7 fires when lo_i <= addr_i <= hi_i, inclusive at both bounds. Mode 8 fires when addr_i < lo_i or addr_i > hi_i.
- R7: Mode 3 (event B) raises store_o for one cycle, one clock after each match_b_i cycle. Mode 4 (A then event B) does the same, but only for match_b_i cycles after an earlier match_a_i cycle. Modes 3 and 4 never set trig_o.
- R8: Mode codes 9 to 15 are reserved and never set trig_o or store_o.
- R9: trig_o rises one clock after the qualifying cycle and stays 1 until the next arm. Further matches while it is set have no effect.
- R10: With cap_begin_i=0 latched (end-at-trigger), cap_en_o is 1 from the clock after the arm until the clock on which trig_o rises, and falls together with it.
- R11: With cap_begin_i=1 latched (begin-at-trigger), cap_en_o is 0 after the arm and rises together with trig_o, then stays 1 until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm strobe: latch configuration, clear sequence |
| mode_i | input | 4 | Trigger condition code 0..8, 9..15 reserved |
| cap_begin_i | input | 1 | 1 = capture begins at trigger, 0 = capture ends at trigger |
| match_a_i | input | 1 | Comparator A hit for this bus cycle |
| match_b_i | input | 1 | Comparator B hit for this bus cycle |
| data_acc_i | input | 1 | This bus cycle is a data access |
| addr_i | input | AW | Bus address of this cycle |
| lo_i | input | AW | Comparator A value, lower window bound |
| hi_i | input | AW | Comparator B value, upper window bound |
| trig_o | output | 1 | Sticky trigger-fired flag |
| cap_en_o | output | 1 | Capture window enable for trace logic |
| store_o | output | 1 | One-cycle data store strobe in event-B modes |

## Verification
All three outputs are registered, so each is due exactly one clock after the bus cycle or arm strobe that causes it. The bench drives inputs 1 ns after a rising edge. Its behavioural model advances on the same edge the design samples. Every output is compared 1 ns after the following edge, which keeps the comparison away from the edge and covers the one-cycle delay, the hold of the sticky flag and the single-cycle width of the store strobe on every clock.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] TM_A_ONLY       = 4'd0;
    localparam logic [MODE_W-1:0] TM_A_OR_B       = 4'd1;
    localparam logic [MODE_W-1:0] TM_A_THEN_B     = 4'd2;
    localparam logic [MODE_W-1:0] TM_EVT_B        = 4'd3;
    localparam logic [MODE_W-1:0] TM_A_THEN_EVT_B = 4'd4;
    localparam logic [MODE_W-1:0] TM_A_AND_B      = 4'd5;
    localparam logic [MODE_W-1:0] TM_A_NOT_B      = 4'd6;
    localparam logic [MODE_W-1:0] TM_IN_RANGE     = 4'd7;
    localparam logic [MODE_W-1:0] TM_OUT_RANGE    = 4'd8;
    localparam logic [MODE_W-1:0] TM_LAST         = TM_OUT_RANGE;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WATCH = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              start_on_trig;
    } trig_cfg_t;

    typedef struct packed {
        logic match_a;
        logic match_b;
        logic data_acc;
        logic in_win;
        logic out_win;
    } bus_obs_t;

    typedef struct packed {
        logic hit;
        logic store;
        logic a_set;
    } eval_res_t;

    function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
        return m > TM_LAST;
    endfunction

    function automatic logic mode_needs_a(input logic [MODE_W-1:0] m);
        return (m == TM_A_THEN_B) || (m == TM_A_THEN_EVT_B);
    endfunction

    function automatic logic mode_is_event(input logic [MODE_W-1:0] m);
        return (m == TM_EVT_B) || (m == TM_A_THEN_EVT_B);
    endfunction

endpackage

// File: rtl/dbg_range_cmp.sv
module dbg_range_cmp #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          in_win,
    output logic          out_win
);
    logic below_lo;
    logic above_hi;

    always_comb begin
        below_lo = addr < lo;
        above_hi = addr > hi;
        in_win   = !below_lo && !above_hi;
        out_win  = below_lo || above_hi;
    end
endmodule

// File: rtl/dbg_trig_eval.sv
module dbg_trig_eval
    import dbg_trig_pkg::*;
(
    input  logic              active,
    input  logic [MODE_W-1:0] mode,
    input  logic              a_seen,
    input  bus_obs_t          obs,
    output eval_res_t         res
);
    logic raw_hit;
    logic raw_store;

    always_comb begin
        raw_hit   = 1'b0;
        raw_store = 1'b0;
        unique case (mode)
            TM_A_ONLY:       raw_hit   = obs.match_a;
            TM_A_OR_B:       raw_hit   = obs.match_a || obs.match_b;
            TM_A_THEN_B:     raw_hit   = a_seen && obs.match_b;
            TM_EVT_B:        raw_store = obs.match_b;
            TM_A_THEN_EVT_B: raw_store = a_seen && obs.match_b;
            TM_A_AND_B:      raw_hit   = obs.match_a && obs.match_b && obs.data_acc;
            TM_A_NOT_B:      raw_hit   = obs.match_a && !obs.match_b && obs.data_acc;
            TM_IN_RANGE:     raw_hit   = obs.in_win;
            TM_OUT_RANGE:    raw_hit   = obs.out_win;
            default: begin
                raw_hit   = 1'b0;
                raw_store = 1'b0;
            end
        endcase
    end

    always_comb begin
        res.hit   = active && raw_hit && !mode_is_event(mode) && !mode_reserved(mode);
        res.store = active && raw_store;
        res.a_set = active && mode_needs_a(mode) && obs.match_a;
    end
endmodule

// File: rtl/dbg_trig_ctl.sv
module dbg_trig_ctl
    import dbg_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      arm,
    input  trig_cfg_t cfg_in,
    input  eval_res_t res,
    output logic      active,
    output logic      a_seen,
    output trig_cfg_t cfg_q,
    output logic      trig,
    output logic      cap_en,
    output logic      store
);
    seq_state_e state_q;

    assign active = (state_q == ST_WATCH) && !arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            a_seen  <= 1'b0;
            trig    <= 1'b0;
            cap_en  <= 1'b0;
            store   <= 1'b0;
        end else if (arm) begin
            state_q <= ST_WATCH;
            cfg_q   <= cfg_in;
            a_seen  <= 1'b0;
            trig    <= 1'b0;
            cap_en  <= !cfg_in.start_on_trig;
            store   <= 1'b0;
        end else begin
            store <= res.store;
            if (res.a_set) begin
                a_seen <= 1'b1;
            end
            if (state_q == ST_WATCH && res.hit) begin
                state_q <= ST_DONE;
                trig    <= 1'b1;
                cap_en  <= cfg_q.start_on_trig;
            end
        end
    end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dbg_trig_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_i,
    input  logic [3:0]    mode_i,
    input  logic          cap_begin_i,
    input  logic          match_a_i,
    input  logic          match_b_i,
    input  logic          data_acc_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] lo_i,
    input  logic [AW-1:0] hi_i,
    output logic          trig_o,
    output logic          cap_en_o,
    output logic          store_o
);
    trig_cfg_t         cfg_in;
    trig_cfg_t         cfg_q;
    bus_obs_t          obs;
    eval_res_t         res;
    logic              active;
    logic              a_seen;
    logic              in_win;
    logic              out_win;
    logic [MODE_W-1:0] act_mode;
    logic              act_start;

    assign cfg_in.mode          = mode_i;
    assign cfg_in.start_on_trig = cap_begin_i;
    assign act_mode             = cfg_q.mode;
    assign act_start            = cfg_q.start_on_trig;

    dbg_range_cmp #(.AW(AW)) u_rng (
        .addr    (addr_i),
        .lo      (lo_i),
        .hi      (hi_i),
        .in_win  (in_win),
        .out_win (out_win)
    );

    assign obs.match_a  = match_a_i;
    assign obs.match_b  = match_b_i;
    assign obs.data_acc = data_acc_i;
    assign obs.in_win   = in_win;
    assign obs.out_win  = out_win;

    dbg_trig_eval u_eval (
        .active (active),
        .mode   (act_mode),
        .a_seen (a_seen),
        .obs    (obs),
        .res    (res)
    );

    dbg_trig_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm_i),
        .cfg_in (cfg_in),
        .res    (res),
        .active (active),
        .a_seen (a_seen),
        .cfg_q  (cfg_q),
        .trig   (trig_o),
        .cap_en (cap_en_o),
        .store  (store_o)
    );
endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk (
    input logic       clk,
    input logic       rst,
    input logic       arm_i,
    input logic [3:0] act_mode,
    input logic       act_start,
    input logic       trig_o,
    input logic       cap_en_o,
    input logic       store_o
);
    // R9
    trig_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o && !arm_i |=> trig_o);

    // R2
    arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> !trig_o && !store_o);

    // R8
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !arm_i && (act_mode > 4'd8) |=> !$rose(trig_o) && !store_o);

    // R7
    event_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
        store_o |-> !trig_o);

    // R10
    end_cap_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o && !act_start |-> !cap_en_o);

    // R11
    begin_cap_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o && act_start |-> cap_en_o);
endmodule

bind dbg_trig_seq dbg_trig_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .arm_i     (arm_i),
    .act_mode  (act_mode),
    .act_start (act_start),
    .trig_o    (trig_o),
    .cap_en_o  (cap_en_o),
    .store_o   (store_o)
);

// File: tb/test_dbg_trig_seq.sv
`timescale 1ns/1ps
module test_dbg_trig_seq;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm_i = 1'b0;
    logic [3:0]    mode_i = '0;
    logic          cap_begin_i = 1'b0;
    logic          match_a_i = 1'b0;
    logic          match_b_i = 1'b0;
    logic          data_acc_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] lo_i = '0;
    logic [AW-1:0] hi_i = '0;
    logic          trig_o;
    logic          cap_en_o;
    logic          store_o;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";

    always #2 clk = ~clk;

    dbg_trig_seq #(.AW(AW)) i_dbg_trig_seq (
        .clk(clk), .rst(rst), .arm_i(arm_i), .mode_i(mode_i),
        .cap_begin_i(cap_begin_i), .match_a_i(match_a_i), .match_b_i(match_b_i),
        .data_acc_i(data_acc_i), .addr_i(addr_i), .lo_i(lo_i), .hi_i(hi_i),
        .trig_o(trig_o), .cap_en_o(cap_en_o), .store_o(store_o)
    );

    // behavioural reference model
    bit m_watch, m_aseen, m_beg, e_trig, e_cap, e_store;
    int m_mode;

    always @(posedge clk) begin
        bit hit, st;
        hit = 0;
        st  = 0;
        if (rst) begin
            m_watch = 0; m_aseen = 0; m_beg = 0; m_mode = 0;
            e_trig = 0; e_cap = 0; e_store = 0;
        end else if (arm_i) begin
            m_watch = 1; m_aseen = 0; m_mode = int'(mode_i); m_beg = cap_begin_i;
            e_trig = 0; e_cap = !cap_begin_i; e_store = 0;
        end else if (m_watch) begin
            case (m_mode)
                0: hit = match_a_i;
                1: hit = match_a_i | match_b_i;
                2: hit = m_aseen & match_b_i;
                3: st  = match_b_i;
                4: st  = m_aseen & match_b_i;
                5: hit = match_a_i & match_b_i & data_acc_i;
                6: hit = match_a_i & !match_b_i & data_acc_i;
                7: hit = (addr_i >= lo_i) && (addr_i <= hi_i);
                8: hit = (addr_i < lo_i) || (addr_i > hi_i);
                default: ;
            endcase
            if ((m_mode == 2 || m_mode == 4) && match_a_i) m_aseen = 1;
            e_store = st;
            if (hit) begin
                m_watch = 0;
                e_trig  = 1;
                e_cap   = m_beg;
            end
        end else begin
            e_store = 0;
        end
    end

    task automatic chk(input string what, input logic act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        chk("trig_o", trig_o, e_trig);
        chk("cap_en_o", cap_en_o, e_cap);
        chk("store_o", store_o, e_store);
    endtask

    task automatic bus(input bit a, input bit b, input bit d, input int ad);
        match_a_i  = a;
        match_b_i  = b;
        data_acc_i = d;
        addr_i     = AW'(ad);
        tick();
    endtask

    task automatic arm(input int m, input bit beg);
        arm_i       = 1;
        mode_i      = 4'(m);
        cap_begin_i = beg;
        match_a_i   = 1;
        match_b_i   = 1;
        data_acc_i  = 1;
        tick();
        arm_i      = 0;
        match_a_i  = 0;
        match_b_i  = 0;
        data_acc_i = 0;
    endtask

    task automatic expect_bit(input string what, input logic act, input bit exp);
        chk(what, act, exp);
    endtask

    initial begin
        lo_i = 16'h0100;
        hi_i = 16'h0200;
        #1;
        cur_req = "R1";
        repeat (3) tick();
        rst = 0;
        bus(1, 1, 1, 'h150);
        bus(1, 0, 1, 'h0);
        expect_bit("trig_o idle", trig_o, 0);

        cur_req = "R3";
        arm(0, 0);
        cur_req = "R10";
        bus(0, 1, 0, 0);
        expect_bit("cap_en_o open before trigger", cap_en_o, 1);
        cur_req = "R3";
        bus(1, 0, 0, 0);
        expect_bit("trig_o after A", trig_o, 1);
        cur_req = "R10";
        expect_bit("cap_en_o closed at trigger", cap_en_o, 0);
        cur_req = "R9";
        bus(1, 1, 1, 0);
        bus(0, 0, 0, 0);
        expect_bit("trig_o sticky", trig_o, 1);

        cur_req = "R11";
        arm(1, 1);
        expect_bit("cap_en_o low after arm", cap_en_o, 0);
        bus(0, 0, 0, 0);
        cur_req = "R3";
        bus(0, 1, 0, 0);
        cur_req = "R11";
        expect_bit("cap_en_o opens at trigger", cap_en_o, 1);
        bus(0, 0, 0, 0);
        bus(0, 0, 0, 0);

        cur_req = "R4";
        arm(2, 0);
        bus(0, 1, 0, 0);
        expect_bit("B without prior A", trig_o, 0);
        bus(1, 1, 0, 0);
        expect_bit("A and B same cycle", trig_o, 0);
        bus(0, 1, 0, 0);
        expect_bit("B after A", trig_o, 1);

        cur_req = "R5";
        arm(5, 0);
        bus(1, 1, 0, 0);
        bus(1, 0, 1, 0);
        expect_bit("A&B full needs all", trig_o, 0);
        bus(1, 1, 1, 0);
        expect_bit("A&B full fires", trig_o, 1);
        arm(6, 1);
        bus(1, 1, 1, 0);
        bus(1, 0, 0, 0);
        expect_bit("A&!B no fire", trig_o, 0);
        bus(1, 0, 1, 0);
        expect_bit("A&!B fires", trig_o, 1);

        cur_req = "R6";
        arm(7, 0);
        bus(0, 0, 0, 'h00FF);
        bus(0, 0, 0, 'h0201);
        expect_bit("outside of window", trig_o, 0);
        bus(0, 0, 0, 'h0100);
        expect_bit("inclusive low bound", trig_o, 1);
        arm(7, 0);
        bus(0, 0, 0, 'h0200);
        expect_bit("inclusive high bound", trig_o, 1);
        arm(8, 1);
        bus(0, 0, 0, 'h0200);
        bus(0, 0, 0, 'h0100);
        bus(0, 0, 0, 'h0150);
        expect_bit("outside mode on bounds", trig_o, 0);
        bus(0, 0, 0, 'h0201);
        expect_bit("above high bound", trig_o, 1);
        arm(8, 0);
        bus(0, 0, 0, 'h00FF);
        expect_bit("below low bound", trig_o, 1);

        cur_req = "R7";
        arm(3, 0);
        bus(0, 1, 1, 0);
        expect_bit("event B store", store_o, 1);
        bus(0, 0, 0, 0);
        expect_bit("store one cycle", store_o, 0);
        bus(1, 1, 1, 0);
        bus(0, 1, 0, 0);
        expect_bit("event mode never fires", trig_o, 0);
        arm(4, 0);
        bus(0, 1, 0, 0);
        expect_bit("B before A no store", store_o, 0);
        bus(1, 0, 0, 0);
        bus(0, 1, 0, 0);
        expect_bit("B after A stores", store_o, 1);
        bus(0, 0, 0, 0);

        cur_req = "R8";
        for (int m = 9; m < 16; m++) begin
            arm(m, 0);
            bus(1, 1, 1, 'h0150);
            bus(1, 0, 1, 'h0000);
            bus(0, 1, 1, 'hFFFF);
            expect_bit("reserved mode quiet", trig_o, 0);
        end

        cur_req = "R2";
        arm(0, 0);
        expect_bit("arm cycle not evaluated", trig_o, 0);
        mode_i = 4'd3;
        cap_begin_i = 1;
        bus(1, 0, 0, 0);
        expect_bit("mode latched at arm", trig_o, 1);
        expect_bit("start select latched at arm", cap_en_o, 0);
        arm(2, 0);
        expect_bit("arm clears trig", trig_o, 0);
        bus(1, 0, 0, 0);
        arm(2, 0);
        bus(0, 1, 0, 0);
        expect_bit("arm clears A history", trig_o, 0);

        rst = 1;
        cur_req = "R1";
        tick();
        tick();
        expect_bit("reset clears cap", cap_en_o, 0);
        rst = 0;
        bus(1, 1, 1, 'h150);
        expect_bit("no evaluation before arm", trig_o, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule